// File: doc/BRIEF.md
# Colour Lookup Table with Sequential Component Loading

This block holds a 256-entry colour lookup table of 24-bit entries. A host loads it over byte-wide ports. The host first writes an entry number to the select port. It then writes three colour values to the colour port, one per component, and each value supplies the upper byte of a 16-bit host colour. An internal component phase moves from red to green to blue with each colour write. After the blue write, the complete entry is committed at once and the entry number steps to the next slot, so a whole table can be loaded with one select write.

The same select port also chooses one of a small bank of auxiliary control registers. A write on the auxiliary port stores a byte into the register that the most recent select write named. A separate lookup port takes a pixel index on every clock and returns the stored colour on the following clock.

The component phase is a three-state machine:
- `PH_RED` waits for the red byte and moves to `PH_GREEN` on a colour write.
- `PH_GREEN` waits for the green byte and moves to `PH_BLUE` on a colour write.
- `PH_BLUE` waits for the blue byte. A colour write commits the entry and returns the phase to `PH_RED`.
- A select write forces any state to `PH_RED`.

Top module: `pal_rgb_lut`

## Requirements
- R1: After reset, every table entry reads as zero, the component phase is red, and all four auxiliary registers are zero.
- R2: A select write loads the entry number from `sel_val` and returns the component phase to red. Any red or green byte staged but not yet committed is discarded.
- R3: In each group of three colour writes, the component byte is `col_val[15:8]` and the bytes fill red, green and blue in that order. The lookup output packs an entry as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R4: An entry keeps its previous colour after its red and green writes. It changes only on the clock edge that takes the blue write, and all three components change together.
- R5: After the blue write, the entry number advances by one modulo 256, so entry 255 is followed by entry 0. The next three colour writes fill that next entry.
- R6: `pix_rgb` shows the entry named by `pix_idx` at the previous clock edge. If that entry is committed at the same edge, `pix_rgb` shows the colour it had before the commit, and the new colour appears one clock later.
- R7: When a select write and a colour write occur in the same cycle, the select write takes effect and the colour byte is dropped. No table entry changes.
- R8: An auxiliary write stores `aux_val` into the register chosen by the most recent earlier select write, for selections 0x10, 0x11, 0x20 and 0x21. These registers appear on `aux_regs` as bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R9: An auxiliary write with any other selection changes no register. Auxiliary writes never change the table, the entry number or the component phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_we | input | 1 | Select write strobe |
| sel_val | input | 8 | Entry number or auxiliary register selection |
| col_we | input | 1 | Colour write strobe |
| col_val | input | 16 | Host colour value; bits 15:8 are used |
| aux_we | input | 1 | Auxiliary register write strobe |
| aux_val | input | 8 | Auxiliary register data |
| pix_idx | input | 8 | Lookup index |
| pix_rgb | output | 24 | Looked-up colour, one clock after the index |
| aux_regs | output | 32 | The four auxiliary registers |

## Verification
Two functions can fall in the same cycle: a lookup of an entry and the blue-byte commit of that same entry. The bench provokes this directly by holding `pix_idx` on the entry under construction while its blue byte is written. It also provokes it in the random phase, which keeps the lookup index near the entry number being loaded. The bench judges the result against its model: the first cycle must return the old colour and the next cycle the new one. The second collision, a select write in the same cycle as a colour write, is judged by whether the table and the loading order are unchanged.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_t;

    localparam int AUX_COUNT = 4;

    // Selection code decoded by each auxiliary register slot.
    function automatic logic [7:0] aux_slot_code(input int slot);
        case (slot)
            0:       return 8'h10;
            1:       return 8'h11;
            2:       return 8'h20;
            default: return 8'h21;
        endcase
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    localparam int RGB_W = 3 * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_val,
    input  logic              col_we,
    input  logic [COMP_W-1:0] comp_byte,
    output logic              commit_we,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [RGB_W-1:0]  commit_rgb
);

    phase_t             phase_q, phase_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic [COMP_W-1:0]  red_q, green_q;
    logic               col_take;

    assign col_take = col_we && !sel_we;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        if (sel_we) begin
            phase_d = PH_RED;
        end else if (col_we) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE:  phase_d = PH_RED;
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
        end else begin
            phase_q <= phase_d;
        end
    end

    // outputs towards the table
    always_comb begin
        commit_we  = 1'b0;
        commit_idx = idx_q;
        commit_rgb = {red_q, green_q, comp_byte};
        idx_d      = idx_q;
        if (sel_we) begin
            idx_d = sel_val;
        end else if (col_take) begin
            unique case (phase_q)
                PH_RED:   idx_d = idx_q;
                PH_GREEN: idx_d = idx_q;
                PH_BLUE: begin
                    commit_we = 1'b1;
                    idx_d     = idx_q + 1'b1;
                end
                default:  idx_d = idx_q;
            endcase
        end
    end

    // entry number and staged components
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            red_q   <= '0;
            green_q <= '0;
        end else begin
            idx_q <= idx_d;
            if (col_take && phase_q == PH_RED)   red_q   <= comp_byte;
            if (col_take && phase_q == PH_GREEN) green_q <= comp_byte;
        end
    end

    AST_SEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> (phase_q == PH_RED && idx_q == $past(sel_val))); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_we && !sel_we && phase_q == PH_RED) |=> phase_q == PH_GREEN); // R3

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_we && !sel_we && phase_q == PH_BLUE) |=> (idx_q == $past(idx_q) + 1'b1 && phase_q == PH_RED)); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_we && !(col_we && phase_q == PH_BLUE)) |=> $stable(idx_q)); // R4

endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int IDX_W = 8,
    parameter int RGB_W = 24,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb
);

    logic [RGB_W-1:0] table_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                table_q[e] <= '0;
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_rgb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_rgb <= '0;
        end else begin
            rd_rgb <= table_q[rd_idx];
        end
    end

    AST_READ_BEFORE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_idx == wr_idx) |=> rd_rgb == $past(table_q[rd_idx])); // R6

endmodule

// File: rtl/pal_auxbank.sv
module pal_auxbank
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    localparam int BUS_W = AUX_COUNT * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_val,
    input  logic              aux_we,
    input  logic [DATA_W-1:0] aux_val,
    output logic [BUS_W-1:0]  aux_regs
);

    logic [IDX_W-1:0]     sel_q;
    logic [AUX_COUNT-1:0] slot_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_val;
        end
    end

    for (genvar s = 0; s < AUX_COUNT; s++) begin : g_slot
        logic [DATA_W-1:0] reg_q;

        assign slot_hit[s] = (sel_q == IDX_W'(aux_slot_code(s)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (aux_we && slot_hit[s]) begin
                reg_q <= aux_val;
            end
        end

        assign aux_regs[s*DATA_W +: DATA_W] = reg_q;
    end

    AST_AUX_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_we |=> $stable(aux_regs)); // R9

    AST_AUX_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_we && slot_hit == '0) |=> $stable(aux_regs)); // R9

    AST_AUX_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit)); // R8

endmodule

// File: rtl/pal_rgb_lut.sv
module pal_rgb_lut
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int HOST_W = 16,
    localparam int RGB_W = 3 * COMP_W,
    localparam int AUX_W = AUX_COUNT * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [IDX_W-1:0]  sel_val,
    input  logic              col_we,
    input  logic [HOST_W-1:0] col_val,
    input  logic              aux_we,
    input  logic [COMP_W-1:0] aux_val,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [RGB_W-1:0]  pix_rgb,
    output logic [AUX_W-1:0]  aux_regs
);

    logic              commit_we;
    logic [IDX_W-1:0]  commit_idx;
    logic [RGB_W-1:0]  commit_rgb;
    logic [COMP_W-1:0] comp_byte;
    logic              unused_low;

    assign comp_byte  = col_val[HOST_W-1 -: COMP_W];
    assign unused_low = ^col_val[HOST_W-COMP_W-1:0];

    pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_val    (sel_val),
        .col_we     (col_we),
        .comp_byte  (comp_byte),
        .commit_we  (commit_we),
        .commit_idx (commit_idx),
        .commit_rgb (commit_rgb)
    );

    pal_store #(.IDX_W(IDX_W), .RGB_W(RGB_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit_we),
        .wr_idx (commit_idx),
        .wr_rgb (commit_rgb),
        .rd_idx (pix_idx),
        .rd_rgb (pix_rgb)
    );

    pal_auxbank #(.IDX_W(IDX_W), .DATA_W(COMP_W)) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (sel_we),
        .sel_val  (sel_val),
        .aux_we   (aux_we),
        .aux_val  (aux_val),
        .aux_regs (aux_regs)
    );

    AST_SEL_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |-> !commit_we); // R7

endmodule

// File: tb/pal_rgb_lut_test.sv
`timescale 1ns/1ps
module pal_rgb_lut_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_val = '0;
    logic        col_we = 1'b0;
    logic [15:0] col_val = '0;
    logic        aux_we = 1'b0;
    logic [7:0]  aux_val = '0;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic [31:0] aux_regs;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [23:0] m_tab [256];
    logic [7:0]  m_idx = '0;
    int          m_ph = 0;
    logic [7:0]  m_red = '0, m_green = '0;
    logic [7:0]  m_sel = '0;
    logic [31:0] m_aux = '0;

    always #2 clk = ~clk;

    pal_rgb_lut uut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_val(sel_val),
        .col_we(col_we), .col_val(col_val), .aux_we(aux_we), .aux_val(aux_val),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb), .aux_regs(aux_regs)
    );

    function automatic int aux_slot(input logic [7:0] s);
        case (s)
            8'h10: return 0;
            8'h11: return 1;
            8'h20: return 2;
            8'h21: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, check after the edge
    task automatic cyc(input logic sw, input logic [7:0] sv,
                       input logic cw, input logic [15:0] cv,
                       input logic aw, input logic [7:0] av,
                       input logic [7:0] px, input string tag);
        logic [23:0] exp_rgb;
        int slot;
        sel_we = sw; sel_val = sv; col_we = cw; col_val = cv;
        aux_we = aw; aux_val = av; pix_idx = px;
        exp_rgb = m_tab[px];
        if (aw) begin
            slot = aux_slot(m_sel);
            if (slot >= 0) m_aux[slot*8 +: 8] = av;
        end
        if (sw) begin
            m_sel = sv;
            m_idx = sv;
            m_ph  = 0;
        end else if (cw) begin
            case (m_ph)
                0: begin m_red = cv[15:8]; m_ph = 1; end
                1: begin m_green = cv[15:8]; m_ph = 2; end
                default: begin
                    m_tab[m_idx] = {m_red, m_green, cv[15:8]};
                    m_idx = m_idx + 8'd1;
                    m_ph = 0;
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check({8'h0, pix_rgb}, {8'h0, exp_rgb}, tag);
        check(aux_regs, m_aux, tag);
        sel_we = 0; col_we = 0; aux_we = 0;
    endtask

    task automatic idle(input logic [7:0] px, input string tag);
        cyc(0, 8'h0, 0, 16'h0, 0, 8'h0, px, tag);
    endtask

    task automatic col(input logic [7:0] b, input logic [7:0] px, input string tag);
        cyc(0, 8'h0, 1, {b, ~b}, 0, 8'h0, px, tag);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int e = 0; e < 256; e++) m_tab[e] = '0;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents
        idle(8'd0, "R1");
        idle(8'd255, "R1");
        idle(8'd77, "R1");

        // R3: fill entry 5 in order, R4: not visible early
        cyc(1, 8'd5, 0, 16'h0, 0, 8'h0, 8'd5, "R2");
        col(8'hA1, 8'd5, "R4");
        col(8'hB2, 8'd5, "R4");
        col(8'hC3, 8'd5, "R6");          // commit while looking up entry 5: old
        idle(8'd5, "R3");                // now A1B2C3
        // R5: next entry without a select write
        col(8'h11, 8'd6, "R5");
        col(8'h22, 8'd6, "R5");
        col(8'h33, 8'd6, "R5");
        idle(8'd6, "R5");

        // R2: select write discards staged bytes
        cyc(1, 8'd9, 0, 16'h0, 0, 8'h0, 8'd9, "R2");
        col(8'hEE, 8'd9, "R2");
        cyc(1, 8'd9, 0, 16'h0, 0, 8'h0, 8'd9, "R2");
        col(8'h01, 8'd9, "R2");
        col(8'h02, 8'd9, "R2");
        col(8'h03, 8'd9, "R2");
        idle(8'd9, "R2");

        // R5: wrap from 255 to 0
        cyc(1, 8'd255, 0, 16'h0, 0, 8'h0, 8'd255, "R5");
        col(8'h44, 8'd255, "R5");
        col(8'h55, 8'd255, "R5");
        col(8'h66, 8'd255, "R5");
        col(8'h77, 8'd0, "R5");
        col(8'h88, 8'd0, "R5");
        col(8'h99, 8'd0, "R5");
        idle(8'd255, "R5");
        idle(8'd0, "R5");

        // R7: select and colour in the same cycle
        cyc(1, 8'd20, 0, 16'h0, 0, 8'h0, 8'd20, "R7");
        col(8'h10, 8'd20, "R7");
        col(8'h20, 8'd20, "R7");
        cyc(1, 8'd20, 1, 16'hFF00, 0, 8'h0, 8'd20, "R7");
        col(8'h5A, 8'd20, "R7");
        col(8'h6B, 8'd20, "R7");
        col(8'h7C, 8'd20, "R7");
        idle(8'd20, "R7");

        // R8: auxiliary registers
        cyc(1, 8'h10, 0, 16'h0, 0, 8'h0, 8'd0, "R8");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'hA5, 8'd0, "R8");
        cyc(1, 8'h11, 0, 16'h0, 0, 8'h0, 8'd0, "R8");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'h3C, 8'd0, "R8");
        cyc(1, 8'h20, 0, 16'h0, 0, 8'h0, 8'd0, "R8");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'h7E, 8'd0, "R8");
        cyc(1, 8'h21, 0, 16'h0, 0, 8'h0, 8'd0, "R8");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'hC9, 8'd0, "R8");
        // R9: other selection ignored, no effect on loading
        cyc(1, 8'h12, 0, 16'h0, 0, 8'h0, 8'd0, "R9");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'hFF, 8'd0, "R9");
        col(8'hD1, 8'd18, "R9");
        cyc(0, 8'h0, 0, 16'h0, 1, 8'h00, 8'd18, "R9");
        col(8'hD2, 8'd18, "R9");
        col(8'hD3, 8'd18, "R9");
        idle(8'd18, "R9");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic sw, cw, aw;
            logic [7:0] sv, px;
            int r;
            r  = $urandom_range(0, 99);
            sw = (r < 8);
            cw = ($urandom_range(0, 99) < 60);
            aw = ($urandom_range(0, 99) < 10);
            case ($urandom_range(0, 3))
                0: sv = 8'h10 + 8'($urandom_range(0, 1));
                1: sv = 8'h20 + 8'($urandom_range(0, 1));
                default: sv = 8'($urandom);
            endcase
            px = ($urandom_range(0, 1) == 0) ? m_idx : 8'($urandom);
            cyc(sw, sv, cw, 16'($urandom), aw, 8'($urandom), px, "R3 R5 R6 R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule